// File: doc/BRIEF.md
# Fs/N Quadrature Carrier Mixer

This block is a digital I/Q mixer that runs at the converter output sample rate, after the interpolation stages. Each accepted sample pair is multiplied by a carrier whose frequency is a fixed fraction of the sample rate: one half, one quarter or one eighth. The mixer can also pass samples through untouched. The carrier phase advances in steps of 45 degrees. It comes from a 3-bit counter and a small coefficient lookup, so every carrier value is one of 0, ±1 or ±√2/2.

Two mixing styles are provided. In real mixing, each channel is scaled by the cosine carrier on its own and the channels never interact. In complex mixing, the I/Q pair is treated as one complex sample and rotated by a phasor. A control bit picks the direction of rotation, so a downstream analog quadrature modulator can suppress either the upper or the lower image. Both styles, and the pass-through mode, have the same two-cycle latency, so I and Q always leave together.

Top module: `quad_carrier_mixer`

## Requirements
- R1: While `rst` is high, and on the first cycle after it falls, `out_valid` is 0 and `out_i`/`out_q` are 0. The reset also returns the carrier phase to 0.
- R2: A sample accepted with `in_valid` high on clock edge k shows up at the outputs with `out_valid` high after edge k+2, in every mode. `out_valid` is low after edge k+1 unless an earlier sample is due.
- R3: With `mod_sel` = 00, the outputs equal the inputs, sign-extended, whatever the values of `real_mix` and `rot_pos`.
- R4: The carrier phase p (angle p·45°) is 0 for the first sample. It advances by 4, 2 or 1 (modulo 8) per accepted sample for `mod_sel` 01 (fs/2), 10 (fs/4) and 11 (fs/8). Cycles without `in_valid` do not advance it.
- R5: With `real_mix` = 1: out_i = I·cos(p·45°) and out_q = Q·cos(p·45°).
- R6: With `real_mix` = 0 and `rot_pos` = 1: out_i = I·cos − Q·sin and out_q = I·sin + Q·cos.
- R7: With `real_mix` = 0 and `rot_pos` = 0, the sine is negated: out_i = I·cos + Q·sin and out_q = Q·cos − I·sin.
- R8: A ±√2/2 product is ±round(x·46341/65536), rounding halves upward, and the minus case is the negation of the plus case. Only fs/8 uses odd phases, so fs/2 and fs/4 produce exact products.
- R9: A sample presented in a cycle where `mod_sel` differs from its value in the previous cycle uses phase 0.
- R10: `out_i` and `out_q` hold their values on every cycle that delivers no new sample.
- R11: The outputs are one bit wider than the inputs, and full-scale inputs never overflow them (for example −32768 negated gives +32768).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Output-rate clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample strobe |
| in_i | input | DW | Signed I sample |
| in_q | input | DW | Signed Q sample |
| mod_sel | input | 2 | Carrier: 00 none, 01 fs/2, 10 fs/4, 11 fs/8 |
| real_mix | input | 1 | 1 = independent real mixing, 0 = complex rotation |
| rot_pos | input | 1 | Complex rotation sign: 1 = e^+jwt, 0 = e^-jwt |
| out_valid | output | 1 | Output sample strobe |
| out_i | output | DW+1 | Signed mixed I |
| out_q | output | DW+1 | Signed mixed Q |

## Verification
Every mixed result is due exactly two rising edges after the edge that accepts its sample. The first edge registers the four carrier products and the second registers the combined sum. The bench drives each input on a falling edge, drops the strobe on the next falling edge, and reads the outputs on the falling edge after that. It also checks that `out_valid` is still low one falling edge after the sample. A back-to-back burst checks that consecutive samples emerge on consecutive cycles, and that the last output is still held several idle cycles later. Expected carrier phases are tracked in the bench from the step rules, counting only strobed samples and restarting at every mode change.

// File: rtl/qmix_pkg.sv
package qmix_pkg;

  localparam int PHW = 3;

  typedef enum logic [1:0] {
    MOD_OFF     = 2'b00,
    MOD_HALF    = 2'b01,
    MOD_QUARTER = 2'b10,
    MOD_EIGHTH  = 2'b11
  } mod_e;

  // carrier value classes at a 45-degree phase grid
  typedef enum logic [2:0] {
    K_ZERO,
    K_ONE,
    K_MONE,
    K_HRT,
    K_MHRT
  } coef_e;

  function automatic logic [PHW-1:0] phase_step(mod_e m);
    case (m)
      MOD_HALF:    return PHW'(4);
      MOD_QUARTER: return PHW'(2);
      MOD_EIGHTH:  return PHW'(1);
      default:     return '0;
    endcase
  endfunction

endpackage

// File: rtl/qmix_phase_gen.sv
module qmix_phase_gen
  import qmix_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  logic           adv,
  input  mod_e           mode,
  output logic [PHW-1:0] phase
);

  mod_e           mode_q;
  logic [PHW-1:0] cnt;
  logic           changed;

  assign changed = (mode != mode_q);
  assign phase   = changed ? '0 : cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= MOD_OFF;
      cnt    <= '0;
    end else begin
      mode_q <= mode;
      cnt    <= adv ? phase + phase_step(mode) : phase;
    end
  end

  // fs/2 keeps the phase on the 0/180 degree points
  assert_half_even_R4: assert property (@(posedge clk) disable iff (rst)
    (adv && mode == MOD_HALF && mode_q == MOD_HALF) |=> (cnt[1:0] == 2'b00));

  // a mode change with no sample leaves the counter at zero
  assert_change_clears_R9: assert property (@(posedge clk) disable iff (rst)
    (changed && !adv) |=> (cnt == '0));

  // pass-through never moves the phase away from zero
  assert_off_frozen_R3: assert property (@(posedge clk) disable iff (rst)
    (mode == MOD_OFF) |=> (cnt == '0));

endmodule

// File: rtl/qmix_carrier_lut.sv
module qmix_carrier_lut
  import qmix_pkg::*;
(
  input  logic [PHW-1:0] phase,
  output coef_e          cos_k,
  output coef_e          sin_k
);

  function automatic coef_e cos_class(logic [PHW-1:0] p);
    case (p)
      3'd0:    return K_ONE;
      3'd1:    return K_HRT;
      3'd2:    return K_ZERO;
      3'd3:    return K_MHRT;
      3'd4:    return K_MONE;
      3'd5:    return K_MHRT;
      3'd6:    return K_ZERO;
      default: return K_HRT;
    endcase
  endfunction

  // sin(p) = cos(p - 90 degrees)
  assign cos_k = cos_class(phase);
  assign sin_k = cos_class(phase - PHW'(2));

  always_comb begin
    if (!phase[0]) begin
      assert_unit_carrier_R8: assert (cos_k != K_HRT && cos_k != K_MHRT &&
                                      sin_k != K_HRT && sin_k != K_MHRT);
    end
  end

endmodule

// File: rtl/qmix_term.sv
module qmix_term
  import qmix_pkg::*;
#(
  parameter int DW   = 16,
  parameter int FRAC = 16
) (
  input  logic signed [DW-1:0] x,
  input  coef_e                kind,
  output logic signed [DW:0]   y
);

  localparam int PW = DW + FRAC + 2;
  localparam longint HK = longint'($rtoi(0.70710678118654752 * (2.0 ** FRAC) + 0.5));
  localparam logic signed [PW-1:0] KV  = PW'(HK);
  localparam logic signed [PW-1:0] RND = {{(PW-FRAC){1'b0}}, 1'b1, {(FRAC-1){1'b0}}};

  logic signed [PW-1:0] xs, prod, scaled;
  logic signed [DW:0]   xe, hp;

  assign xs     = PW'(x);
  assign prod   = xs * KV;
  assign scaled = (prod + RND) >>> FRAC;
  assign hp     = scaled[DW:0];
  assign xe     = {x[DW-1], x};

  always_comb begin
    case (kind)
      K_ONE:   y = xe;
      K_MONE:  y = -xe;
      K_HRT:   y = hp;
      K_MHRT:  y = -hp;
      default: y = '0;
    endcase
  end

  always_comb begin
    assert_term_fits_R11: assert (scaled == PW'(hp));
  end

endmodule

// File: rtl/quad_carrier_mixer.sv
module quad_carrier_mixer
  import qmix_pkg::*;
#(
  parameter int DW   = 16,
  parameter int FRAC = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [DW-1:0]     in_i,
  input  logic [DW-1:0]     in_q,
  input  logic [1:0]        mod_sel,
  input  logic              real_mix,
  input  logic              rot_pos,
  output logic              out_valid,
  output logic [DW:0]       out_i,
  output logic [DW:0]       out_q
);

  localparam int NT = 4;   // I*cos, Q*sin, I*sin, Q*cos
  localparam int OW = DW + 1;
  localparam int SW = DW + 2;

  mod_e           mode_in;
  logic [PHW-1:0] phase;
  coef_e          cos_k, sin_k;

  assign mode_in = mod_e'(mod_sel);

  qmix_phase_gen u_phase (
    .clk   (clk),
    .rst   (rst),
    .adv   (in_valid),
    .mode  (mode_in),
    .phase (phase)
  );

  qmix_carrier_lut u_lut (
    .phase (phase),
    .cos_k (cos_k),
    .sin_k (sin_k)
  );

  logic signed [DW-1:0] src  [NT];
  coef_e                knd  [NT];
  logic signed [OW-1:0] term [NT];
  logic signed [OW-1:0] t_s1 [NT];

  assign src[0] = in_i; assign knd[0] = cos_k;
  assign src[1] = in_q; assign knd[1] = sin_k;
  assign src[2] = in_i; assign knd[2] = sin_k;
  assign src[3] = in_q; assign knd[3] = cos_k;

  for (genvar g = 0; g < NT; g++) begin : g_term
    qmix_term #(.DW(DW), .FRAC(FRAC)) u_term (
      .x    (src[g]),
      .kind (knd[g]),
      .y    (term[g])
    );
  end

  // stage 1: carrier products
  logic s1_valid, s1_real, s1_pos;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_real  <= 1'b0;
      s1_pos   <= 1'b0;
      for (int k = 0; k < NT; k++) t_s1[k] <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_real <= real_mix;
        s1_pos  <= rot_pos;
        for (int k = 0; k < NT; k++) t_s1[k] <= term[k];
      end
    end
  end

  // stage 2: combine into real or complex result
  logic signed [SW-1:0] ic, qs, is, qc, sum_i, sum_q;

  assign ic = SW'(t_s1[0]);
  assign qs = SW'(t_s1[1]);
  assign is = SW'(t_s1[2]);
  assign qc = SW'(t_s1[3]);

  always_comb begin
    if (s1_real) begin
      sum_i = ic;
      sum_q = qc;
    end else if (s1_pos) begin
      sum_i = ic - qs;
      sum_q = is + qc;
    end else begin
      sum_i = ic + qs;
      sum_q = qc - is;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_i     <= '0;
      out_q     <= '0;
    end else begin
      out_valid <= s1_valid;
      if (s1_valid) begin
        out_i <= sum_i[OW-1:0];
        out_q <= sum_q[OW-1:0];
      end
    end
  end

  // ---------------- assertions ----------------
  logic [1:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end

  always_comb begin
    if (!rst) begin
      assert_no_overflow_R11: assert (sum_i[SW-1] == sum_i[SW-2] && sum_q[SW-1] == sum_q[SW-2]);
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_i == '0 && out_q == '0));

  assert_fixed_latency_R2: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 2'd2) |-> (out_valid == $past(in_valid, 2)));

  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (rst)
    !s1_valid |=> ($stable(out_i) && $stable(out_q)));

endmodule

// File: tb/test_quad_carrier_mixer.sv
module test_quad_carrier_mixer;

  localparam int DW = 16;
  localparam int NV = 17;

  logic              clk = 1'b0;
  logic              rst;
  logic              in_valid;
  logic [DW-1:0]     in_i, in_q;
  logic [1:0]        mod_sel;
  logic              real_mix, rot_pos;
  logic              out_valid;
  logic [DW:0]       out_i, out_q;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  quad_carrier_mixer #(.DW(DW)) i_quad_carrier_mixer (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_i(in_i), .in_q(in_q),
    .mod_sel(mod_sel), .real_mix(real_mix), .rot_pos(rot_pos),
    .out_valid(out_valid), .out_i(out_i), .out_q(out_q)
  );

  // {mode, real, pos, i, q, exp_i, exp_q}; phases follow R4 from reset
  localparam logic [69:0] VEC [NV] = '{
    {2'd0, 1'b1, 1'b0,  16'sd1000, -16'sd2000,  17'sd1000, -17'sd2000},
    {2'd0, 1'b0, 1'b1, -16'sd5,     16'sd7,    -17'sd5,     17'sd7},
    {2'd1, 1'b1, 1'b0,  16'sd300,   16'sd400,   17'sd300,   17'sd400},
    {2'd1, 1'b1, 1'b0,  16'sd300,   16'sd400,  -17'sd300,  -17'sd400},
    {2'd1, 1'b1, 1'b0, -16'sd32768, 16'sd32767,-17'sd32768, 17'sd32767},
    {2'd2, 1'b1, 1'b0,  16'sd10,    16'sd20,    17'sd10,    17'sd20},
    {2'd2, 1'b1, 1'b0,  16'sd10,    16'sd20,    17'sd0,     17'sd0},
    {2'd2, 1'b1, 1'b0,  16'sd10,    16'sd20,   -17'sd10,   -17'sd20},
    {2'd2, 1'b0, 1'b1,  16'sd10,    16'sd20,    17'sd20,   -17'sd10},
    {2'd2, 1'b0, 1'b1,  16'sd10,    16'sd20,    17'sd10,    17'sd20},
    {2'd2, 1'b0, 1'b1,  16'sd10,    16'sd20,   -17'sd20,    17'sd10},
    {2'd2, 1'b0, 1'b0,  16'sd10,    16'sd20,   -17'sd10,   -17'sd20},
    {2'd2, 1'b0, 1'b0,  16'sd10,    16'sd20,   -17'sd20,    17'sd10},
    {2'd1, 1'b0, 1'b1,  16'sd10,    16'sd20,    17'sd10,    17'sd20},
    {2'd1, 1'b0, 1'b1,  16'sd10,    16'sd20,   -17'sd10,   -17'sd20},
    {2'd1, 1'b0, 1'b1, -16'sd32768,-16'sd32768,-17'sd32768,-17'sd32768},
    {2'd1, 1'b0, 1'b1, -16'sd32768,-16'sd32768, 17'sd32768, 17'sd32768}
  };

  task automatic chk(string tag, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic string tag_for(logic [1:0] m, logic rm, logic rp, longint i);
    if (m == 2'd0) return "R3 passthrough";
    if (i == -32768) return "R11 full scale";
    if (rm) return "R5 R4 real mix";
    if (rp) return "R6 R9 complex e+jwt";
    return "R7 complex e-jwt";
  endfunction

  // carrier class: 2 = +1, 1 = +h, 0 = 0, -1 = -h, -2 = -1
  function automatic int ccode(int p);
    case (p & 7)
      0: return 2;  1: return 1;  2: return 0;  3: return -1;
      4: return -2; 5: return -1; 6: return 0;  default: return 1;
    endcase
  endfunction

  function automatic longint mk(longint x, int k);
    longint h;
    h = (x * 46341 + 32768) >>> 16;
    case (k)
      2: return x;   -2: return -x;
      1: return h;   -1: return -h;
      default: return 0;
    endcase
  endfunction

  task automatic model(int p, bit rm, bit rp, longint i, longint q,
                       output longint ei, output longint eq);
    longint ic, qs, is, qc;
    ic = mk(i, ccode(p));     qc = mk(q, ccode(p));
    is = mk(i, ccode(p + 6)); qs = mk(q, ccode(p + 6));
    if (rm)      begin ei = ic;      eq = qc;      end
    else if (rp) begin ei = ic - qs; eq = is + qc; end
    else         begin ei = ic + qs; eq = qc - is; end
  endtask

  // called at a falling edge, returns at a falling edge
  task automatic run_one(logic [1:0] m, bit rm, bit rp, longint i, longint q,
                         longint ei, longint eq, string tag);
    mod_sel = m; real_mix = rm; rot_pos = rp;
    in_i = DW'(i); in_q = DW'(q); in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 no output after one edge", longint'(out_valid), 0);
    @(negedge clk);
    chk("R2 output after two edges", longint'(out_valid), 1);
    chk({tag, " out_i"}, longint'($signed(out_i)), ei);
    chk({tag, " out_q"}, longint'($signed(out_q)), eq);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint ei, eq, ea_i, ea_q, eb_i, eb_q, ec_i, ec_q;
    int ph;
    rst = 1'b1; in_valid = 1'b0; in_i = '0; in_q = '0;
    mod_sel = 2'd0; real_mix = 1'b1; rot_pos = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", longint'(out_valid), 0);
    chk("R1 reset out_i", longint'($signed(out_i)), 0);
    chk("R1 reset out_q", longint'($signed(out_q)), 0);
    rst = 1'b0;
    @(negedge clk);

    // vector table
    for (int v = 0; v < NV; v++) begin
      logic [69:0] e;
      e = VEC[v];
      run_one(e[69:68], e[67], e[66],
              longint'($signed(e[65:50])), longint'($signed(e[49:34])),
              longint'($signed(e[33:17])), longint'($signed(e[16:0])),
              tag_for(e[69:68], e[67], e[66], longint'($signed(e[65:50]))));
    end

    // fs/8 sweep: mode change restarts at phase 0 (R9), sqrt2/2 rounding (R8)
    ph = 0;
    for (int s = 0; s < 3; s++) begin
      for (int k = 0; k < 8; k++) begin
        longint xi, xq;
        xi = (k % 2 == 0) ? -12345 + k * 301 : 1000 + k * 77;
        xq = (k % 3 == 0) ? 777 - k * 55 : -3001 + k;
        model(ph, s == 2, s == 0, xi, xq, ei, eq);
        run_one(2'd3, s == 2, s == 0, xi, xq, ei, eq,
                s == 0 ? "R8 R6 fs/8 e+jwt" : (s == 1 ? "R8 R7 fs/8 e-jwt" : "R8 R5 fs/8 real"));
        ph = (ph + 1) % 8;
      end
    end

    // back-to-back burst, fs/8 complex e+jwt (R2), then hold (R10)
    mod_sel = 2'd3; real_mix = 1'b0; rot_pos = 1'b1;
    model(ph, 0, 1, 20001, -15000, ea_i, ea_q);
    model(ph + 1, 0, 1, -7, 32767, eb_i, eb_q);
    model(ph + 2, 0, 1, -32768, 32767, ec_i, ec_q);
    in_i = DW'(20001); in_q = DW'(-15000); in_valid = 1'b1;
    @(negedge clk);
    chk("R2 burst first not early", longint'(out_valid), 0);
    in_i = DW'(-7); in_q = DW'(32767);
    @(negedge clk);
    chk("R2 burst A valid", longint'(out_valid), 1);
    chk("R2 burst A out_i", longint'($signed(out_i)), ea_i);
    chk("R2 burst A out_q", longint'($signed(out_q)), ea_q);
    in_i = DW'(-32768); in_q = DW'(32767);
    @(negedge clk);
    in_valid = 1'b0;
    chk("R2 burst B out_i", longint'($signed(out_i)), eb_i);
    chk("R2 burst B out_q", longint'($signed(out_q)), eb_q);
    @(negedge clk);
    chk("R2 burst C valid", longint'(out_valid), 1);
    chk("R11 burst C out_i", longint'($signed(out_i)), ec_i);
    chk("R11 burst C out_q", longint'($signed(out_q)), ec_q);
    @(negedge clk);
    chk("R2 burst ends", longint'(out_valid), 0);
    in_i = DW'(999); in_q = DW'(-999);
    repeat (4) @(negedge clk);
    chk("R10 hold out_i", longint'($signed(out_i)), ec_i);
    chk("R10 hold out_q", longint'($signed(out_q)), ec_q);

    // reset in mid-run clears outputs and phase (R1)
    rst = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 mid reset out_valid", longint'(out_valid), 0);
    chk("R1 mid reset out_i", longint'($signed(out_i)), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 first cycle after reset", longint'(out_valid), 0);
    run_one(2'd3, 0, 1, 1000, 500, 1000, 500, "R1 phase zero after reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule